// File: doc/BRIEF.md
# Buffered I2C Slave With Host Interrupt Flags

This block is an I2C slave target that has no memory of its own. Each byte passes through a single-byte receive buffer and a single-byte transmit buffer, and host software services both. Software programs a 7-bit device address. When a START and an address byte select the device, the slave acknowledges and sets a match flag. In a write transfer the first data byte (the word address) goes into the receive buffer. A separate flag marks that byte, so software can tell the word address apart from the data bytes that follow it.

Data integrity is kept by back-pressure instead of overwrite. If a byte completes while the receive buffer still holds an unread byte, the new byte is dropped and the slave answers NACK. In a read transfer the transmit buffer is copied into the shift register when the address matches and after each master ACK, and each copy sets the transmit-empty flag. If software has not refilled the buffer in time, the byte it last wrote is sent again. Each flag is cleared by the host access that naturally follows it: a zero-write pulse for the match flag, a buffer read for the receive flag, and a buffer write for the transmit flag.

SCL and SDA are sampled through a synchronizer. SDA is driven open-drain through `sda_oe`. Multi-master arbitration and clock stretching are not part of the block.

Top module: `i2c_buffered_slave`

## Requirements
- R1: After reset, all four flags are 0, `rx_data` is 0x00, `sda_oe` is 0 (SDA released), and the device address is 0x50.
- R2: The first byte after a START carries the address in bits 7..1 and R/W in bit 0 (1 = read), sent MSB first. The slave acknowledges (drives SDA low in the ninth clock) and sets `match_flag` only if all 7 address bits equal the programmed address. On any mismatch it leaves SDA released and changes no flag.
- R3: `match_flag` stays set until the host pulses `match_clr`; bus traffic does not clear it.
- R4: In a write transfer each completed data byte is copied to the receive buffer (`rx_data`) if the buffer is empty. This sets `rx_full_flag` and is acknowledged. The address byte is never buffered.
- R5: `rx_is_waddr` is 1 when the byte in the receive buffer is the first data byte of the transfer, and 0 for every later byte.
- R6: A data byte that completes while `rx_full_flag` is 1 is not stored, the buffer keeps its old byte, and the slave answers NACK.
- R7: A one-cycle `rx_rd` pulse clears `rx_full_flag`.
- R8: On a read-address match the transmit buffer byte is loaded into the shift register and `tx_empty_flag` is set. The byte is then sent MSB first, and SDA changes only while SCL is low.
- R9: A `tx_wr` pulse writes `tx_wdata` into the transmit buffer and clears `tx_empty_flag`. After each master ACK the buffer is loaded again and the flag is set again.
- R10: If the transmit buffer was not rewritten since its last load, the next byte sent repeats the byte last written.
- R11: A repeated START in the middle of a byte abandons that byte and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_wr | input | 1 | Load `addr_wdata` as device address |
| addr_wdata | input | 7 | New device address |
| rx_rd | input | 1 | Host read strobe for the receive buffer |
| rx_data | output | 8 | Receive buffer contents |
| rx_is_waddr | output | 1 | Buffered byte is the word address |
| tx_wr | input | 1 | Host write strobe for the transmit buffer |
| tx_wdata | input | 8 | Byte for the transmit buffer |
| match_clr | input | 1 | Clears the match flag (write-zero action) |
| match_flag | output | 1 | Address matched |
| rx_full_flag | output | 1 | Receive buffer holds an unread byte |
| tx_empty_flag | output | 1 | Transmit buffer was taken by the shift register |

## Verification
A change on SCL or SDA passes two synchronizer stages and one edge register. The flags and `sda_oe` therefore respond on the third clock edge after the line changes. A host strobe updates its flag on the first edge. The bench holds every SCL phase for ten clocks and samples SDA four clocks after each rising edge, well past that three-edge delay. Its reference model is updated at those points, and the per-clock comparison of all flags and `rx_data` is paused only for the four cycles after each rising SCL edge and each host strobe.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t sync_d, sync_q;
    logic  scl_now;

    always_comb begin
        sync_d          = sync_q;
        sync_d.scl_sh   = {sync_q.scl_sh[STAGES-2:0], scl_in};
        sync_d.sda_sh   = {sync_q.sda_sh[STAGES-2:0], sda_in};
        sync_d.scl_prev = sync_q.scl_sh[STAGES-1];
        sync_d.sda_prev = sync_q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= sync_d;
    end

    assign scl_now   = sync_q.scl_sh[STAGES-1];
    assign sda_s     = sync_q.sda_sh[STAGES-1];
    assign scl_rise  = scl_now & ~sync_q.scl_prev;
    assign scl_fall  = ~scl_now & sync_q.scl_prev;
    assign start_evt = scl_now & sync_q.scl_prev & sync_q.sda_prev & ~sda_s;
    assign stop_evt  = scl_now & sync_q.scl_prev & ~sync_q.sda_prev & sda_s;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              rx_full,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_oe,
    output logic              match_evt,
    output logic              rx_store,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_first,
    output logic              tx_take
);
    typedef struct packed {
        bus_state_t        st;
        logic [BYTE_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
        logic              phase;
        logic              ack;
        logic              rd;
        logic              first;
        logic              oe;
    } eng_t;

    localparam eng_t ENG_RST = '{st: ST_IDLE, sr: '0, cnt: '0, phase: 1'b0,
                                 ack: 1'b0, rd: 1'b0, first: 1'b0, oe: 1'b0};

    eng_t              eng_d, eng_q;
    logic [BYTE_W-1:0] nb;
    logic              last;

    assign nb   = {eng_q.sr[BYTE_W-2:0], sda_s};
    assign last = (eng_q.cnt == CNT_W'(BYTE_W - 1));

    always_comb begin
        eng_d     = eng_q;
        match_evt = 1'b0;
        rx_store  = 1'b0;
        tx_take   = 1'b0;
        rx_byte   = nb;
        rx_first  = eng_q.first;
        if (stop_evt) begin
            eng_d.st    = ST_IDLE;
            eng_d.oe    = 1'b0;
            eng_d.phase = 1'b0;
        end else if (start_evt) begin
            eng_d.st    = ST_ADDR;
            eng_d.cnt   = '0;
            eng_d.oe    = 1'b0;
            eng_d.phase = 1'b0;
        end else begin
            case (eng_q.st)
                ST_ADDR: if (scl_rise) begin
                    eng_d.sr  = nb;
                    eng_d.cnt = eng_q.cnt + 1'b1;
                    if (last) begin
                        if (nb[BYTE_W-1:1] == own_addr) begin
                            match_evt   = 1'b1;
                            eng_d.st    = ST_ADDR_ACK;
                            eng_d.rd    = nb[0];
                            eng_d.phase = 1'b0;
                            if (nb[0]) begin
                                tx_take  = 1'b1;
                                eng_d.sr = tx_byte;
                            end
                        end else begin
                            eng_d.st = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    if (!eng_q.phase) begin
                        eng_d.phase = 1'b1;
                        eng_d.oe    = 1'b1;
                    end else begin
                        eng_d.phase = 1'b0;
                        eng_d.cnt   = '0;
                        if (eng_q.rd) begin
                            eng_d.st = ST_TX;
                            eng_d.oe = ~eng_q.sr[BYTE_W-1];
                        end else begin
                            eng_d.st    = ST_RX;
                            eng_d.oe    = 1'b0;
                            eng_d.first = 1'b1;
                        end
                    end
                end
                ST_RX: if (scl_rise) begin
                    eng_d.sr  = nb;
                    eng_d.cnt = eng_q.cnt + 1'b1;
                    if (last) begin
                        eng_d.st    = ST_RX_ACK;
                        eng_d.phase = 1'b0;
                        if (!rx_full) begin
                            rx_store    = 1'b1;
                            eng_d.ack   = 1'b1;
                            eng_d.first = 1'b0;
                        end else begin
                            eng_d.ack = 1'b0;
                        end
                    end
                end
                ST_RX_ACK: if (scl_fall) begin
                    if (!eng_q.phase) begin
                        eng_d.phase = 1'b1;
                        eng_d.oe    = eng_q.ack;
                    end else begin
                        eng_d.phase = 1'b0;
                        eng_d.oe    = 1'b0;
                        eng_d.cnt   = '0;
                        eng_d.st    = ST_RX;
                    end
                end
                ST_TX: if (scl_fall) begin
                    eng_d.cnt = eng_q.cnt + 1'b1;
                    if (last) begin
                        eng_d.st = ST_TX_ACK;
                        eng_d.oe = 1'b0;
                    end else begin
                        eng_d.sr = {eng_q.sr[BYTE_W-2:0], 1'b0};
                        eng_d.oe = ~eng_q.sr[BYTE_W-2];
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        if (!sda_s) begin
                            tx_take   = 1'b1;
                            eng_d.sr  = tx_byte;
                            eng_d.ack = 1'b1;
                        end else begin
                            eng_d.ack = 1'b0;
                        end
                    end else if (scl_fall) begin
                        if (eng_q.ack) begin
                            eng_d.st  = ST_TX;
                            eng_d.cnt = '0;
                            eng_d.oe  = ~eng_q.sr[BYTE_W-1];
                        end else begin
                            eng_d.st = ST_IDLE;
                            eng_d.oe = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= ENG_RST;
        else        eng_q <= eng_d;
    end

    assign sda_oe = eng_q.oe;

    // SDA may only move on an SCL falling edge, or be released by START/STOP
    assert_sda_moves_on_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_fall && !start_evt && !stop_evt) |=> $stable(eng_q.oe));
endmodule

// File: rtl/i2cs_host_regs.sv
module i2cs_host_regs
    import i2cs_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_ADDR = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              rx_rd,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_wdata,
    input  logic              match_clr,
    input  logic              match_evt,
    input  logic              rx_store,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_first,
    input  logic              tx_take,
    output logic [ADDR_W-1:0] own_addr,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_waddr,
    output logic              match_flag,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_empty
);
    typedef struct packed {
        logic [ADDR_W-1:0] own;
        logic [BYTE_W-1:0] rxb;
        logic              full;
        logic              waddr;
        logic              match;
        logic [BYTE_W-1:0] txb;
        logic              empty;
    } regs_t;

    localparam regs_t REGS_RST = '{own: RESET_ADDR, rxb: '0, full: 1'b0,
                                   waddr: 1'b0, match: 1'b0, txb: '0, empty: 1'b0};

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (addr_wr) regs_d.own = addr_wdata;
        if (tx_wr) begin
            regs_d.txb   = tx_wdata;
            regs_d.empty = 1'b0;
        end
        if (tx_take)   regs_d.empty = 1'b1;
        if (rx_rd)     regs_d.full  = 1'b0;
        if (rx_store) begin
            regs_d.rxb   = rx_byte;
            regs_d.full  = 1'b1;
            regs_d.waddr = rx_first;
        end
        if (match_clr) regs_d.match = 1'b0;
        if (match_evt) regs_d.match = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RST;
        else        regs_q <= regs_d;
    end

    assign own_addr   = regs_q.own;
    assign rx_data    = regs_q.rxb;
    assign rx_full    = regs_q.full;
    assign rx_waddr   = regs_q.waddr;
    assign match_flag = regs_q.match;
    assign tx_byte    = regs_q.txb;
    assign tx_empty   = regs_q.empty;

    assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_store |-> !regs_q.full);
    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !rx_store) |=> !regs_q.full);
    assert_take_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> regs_q.empty);
    assert_match_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> regs_q.match);
endmodule

// File: rtl/i2c_buffered_slave.sv
module i2c_buffered_slave
    import i2cs_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] RESET_ADDR  = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              rx_rd,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_is_waddr,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_wdata,
    input  logic              match_clr,
    output logic              match_flag,
    output logic              rx_full_flag,
    output logic              tx_empty_flag
);
    logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic              match_evt, rx_store, rx_first, tx_take;
    logic [BYTE_W-1:0] rx_byte, tx_byte;
    logic [ADDR_W-1:0] own_addr;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    i2cs_engine u_engine (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
        .own_addr(own_addr), .rx_full(rx_full_flag), .tx_byte(tx_byte),
        .sda_oe(sda_oe), .match_evt(match_evt), .rx_store(rx_store),
        .rx_byte(rx_byte), .rx_first(rx_first), .tx_take(tx_take)
    );

    i2cs_host_regs #(.RESET_ADDR(RESET_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .rx_rd(rx_rd), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .match_clr(match_clr),
        .match_evt(match_evt), .rx_store(rx_store), .rx_byte(rx_byte),
        .rx_first(rx_first), .tx_take(tx_take), .own_addr(own_addr),
        .rx_data(rx_data), .rx_full(rx_full_flag), .rx_waddr(rx_is_waddr),
        .match_flag(match_flag), .tx_byte(tx_byte), .tx_empty(tx_empty_flag)
    );
endmodule

// File: tb/i2c_buffered_slave_test.sv
module i2c_buffered_slave_test;
    localparam int H = 10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1, sda_line;
    logic       sda_oe, addr_wr = 1'b0, rx_rd = 1'b0, tx_wr = 1'b0, match_clr = 1'b0;
    logic [6:0] addr_wdata = '0;
    logic [7:0] tx_wdata = '0, rx_data;
    logic       rx_is_waddr, match_flag, rx_full_flag, tx_empty_flag;

    int n_checks = 0, n_err = 0;
    bit mon_en = 1'b0;

    // reference model state
    logic [6:0] exp_own = 7'h50;
    logic       exp_match = 0, exp_rx_full = 0, exp_waddr = 0, exp_tx_empty = 0;
    logic [7:0] exp_rx_data = 8'h00, exp_txbuf = 8'h00, exp_sr = 8'h00;
    logic       exp_active = 0, exp_read = 0, exp_first = 0, exp_ack = 0;
    logic [7:0] cur_byte;
    bit         cur_addr;

    always #2 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    i2c_buffered_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata), .rx_rd(rx_rd), .rx_data(rx_data),
        .rx_is_waddr(rx_is_waddr), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .match_clr(match_clr), .match_flag(match_flag), .rx_full_flag(rx_full_flag),
        .tx_empty_flag(tx_empty_flag)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        #1;
        if (mon_en) begin
            chk("R2 match_flag",     {7'b0, match_flag},    {7'b0, exp_match});
            chk("R4 rx_full_flag",   {7'b0, rx_full_flag},  {7'b0, exp_rx_full});
            chk("R5 rx_is_waddr",    {7'b0, rx_is_waddr},   {7'b0, exp_waddr});
            chk("R4 rx_data",        rx_data,               exp_rx_data);
            chk("R8 tx_empty_flag",  {7'b0, tx_empty_flag}, {7'b0, exp_tx_empty});
        end
    end

    task automatic model_byte();
        if (cur_addr) begin
            if (cur_byte[7:1] == exp_own) begin
                exp_match = 1; exp_ack = 1; exp_active = 1; exp_read = cur_byte[0];
                if (cur_byte[0]) begin exp_sr = exp_txbuf; exp_tx_empty = 1; end
                else exp_first = 1;
            end else begin
                exp_ack = 0; exp_active = 0;
            end
        end else if (exp_active && !exp_read && !exp_rx_full) begin
            exp_rx_full = 1; exp_rx_data = cur_byte; exp_waddr = exp_first;
            exp_first = 0; exp_ack = 1;
        end else begin
            exp_ack = 0;
        end
    endtask

    task automatic drive_bit(input logic b, input bit hook);
        sda_m = b; wclk(H);
        scl_m = 1'b1; mon_en = 0; wclk(4);
        if (hook) model_byte();
        mon_en = 1; wclk(H - 4);
        scl_m = 1'b0; wclk(H);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(H);
        scl_m = 1'b1; wclk(H);
        sda_m = 1'b0; exp_active = 0; wclk(H);
        scl_m = 1'b0; wclk(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(H);
        scl_m = 1'b1; wclk(H);
        sda_m = 1'b1; wclk(H);
    endtask

    task automatic put_byte(input logic [7:0] b, input bit is_addr, input string tag);
        cur_byte = b; cur_addr = is_addr;
        for (int i = 7; i >= 0; i--) drive_bit(b[i], i == 0);
        sda_m = 1'b1; wclk(H);
        scl_m = 1'b1; wclk(4);
        chk(tag, {7'b0, ~sda_line}, {7'b0, exp_ack});
        wclk(H - 4);
        scl_m = 1'b0; wclk(H);
    endtask

    task automatic get_byte(input bit ack, input string tag);
        logic [7:0] got = '0;
        logic [7:0] want = exp_sr;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wclk(H); scl_m = 1'b1; wclk(4);
            got = {got[6:0], sda_line};
            wclk(H - 4); scl_m = 1'b0;
        end
        sda_m = ~ack; wclk(H);
        scl_m = 1'b1; mon_en = 0; wclk(4);
        if (ack) begin exp_sr = exp_txbuf; exp_tx_empty = 1; end
        mon_en = 1; wclk(H - 4);
        scl_m = 1'b0; wclk(2);
        sda_m = 1'b1; wclk(H - 2);
        chk(tag, got, want);
    endtask

    task automatic host_rd(input logic [7:0] v, input string tag);
        @(negedge clk);
        chk(tag, rx_data, v);
        rx_rd = 1; mon_en = 0; wclk(1);
        rx_rd = 0; exp_rx_full = 0; wclk(3); mon_en = 1;
    endtask

    task automatic host_txw(input logic [7:0] v);
        @(negedge clk);
        tx_wdata = v; tx_wr = 1; mon_en = 0; wclk(1);
        tx_wr = 0; exp_txbuf = v; exp_tx_empty = 0; wclk(3); mon_en = 1;
    endtask

    task automatic host_mclr();
        @(negedge clk);
        match_clr = 1; mon_en = 0; wclk(1);
        match_clr = 0; exp_match = 0; wclk(3); mon_en = 1;
    endtask

    task automatic host_addr(input logic [6:0] a);
        @(negedge clk);
        addr_wdata = a; addr_wr = 1; wclk(1);
        addr_wr = 0; exp_own = a; wclk(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        report();
    end

    initial begin
        wclk(5); rst_n = 1'b1; wclk(2);
        // R1 reset state
        chk("R1 flags", {4'b0, match_flag, rx_full_flag, tx_empty_flag, rx_is_waddr}, 8'h00);
        chk("R1 sda_oe", {7'b0, sda_oe}, 8'h00);
        chk("R1 rx_data", rx_data, 8'h00);
        mon_en = 1;

        // R1 default address 0x50: address 0x23 must be ignored (R2 mismatch)
        bus_start(); put_byte(8'h46, 1, "R2 nack foreign address"); bus_stop();
        // R1 default address 0x50 answers
        bus_start(); put_byte(8'hA0, 1, "R1 default address ack"); bus_stop();
        host_mclr();

        host_addr(7'h3A);
        // R2 one address bit differs
        bus_start(); put_byte({7'h3B, 1'b0}, 1, "R2 nack lsb differs"); bus_stop();

        // R4 word address stored, R6 second byte refused
        bus_start();
        put_byte({7'h3A, 1'b0}, 1, "R2 ack own address");
        put_byte(8'h10, 0, "R4 ack word address");
        put_byte(8'hA5, 0, "R6 nack while full");
        bus_stop();
        chk("R6 buffer kept", rx_data, 8'h10);
        host_rd(8'h10, "R7 read word address");
        chk("R7 full cleared", {7'b0, rx_full_flag}, 8'h00);
        chk("R3 match held", {7'b0, match_flag}, 8'h01);
        host_mclr();
        chk("R3 match cleared", {7'b0, match_flag}, 8'h00);

        // R5 word-address marker on first byte only
        bus_start();
        put_byte({7'h3A, 1'b0}, 1, "R2 ack write");
        put_byte(8'h05, 0, "R4 ack first");
        chk("R5 first is word address", {7'b0, rx_is_waddr}, 8'h01);
        host_rd(8'h05, "R4 read first");
        put_byte(8'h77, 0, "R4 ack second");
        chk("R5 second not word address", {7'b0, rx_is_waddr}, 8'h00);
        host_rd(8'h77, "R4 read second");
        bus_stop();

        // R8 read path, R10 repeat, R9 refill
        host_txw(8'hC3);
        bus_start();
        put_byte({7'h3A, 1'b1}, 1, "R8 ack read address");
        chk("R8 tx empty after load", {7'b0, tx_empty_flag}, 8'h01);
        get_byte(1, "R8 first byte");
        host_txw(8'h5A);
        chk("R9 write clears empty", {7'b0, tx_empty_flag}, 8'h00);
        get_byte(1, "R10 repeated byte");
        chk("R9 reload sets empty", {7'b0, tx_empty_flag}, 8'h01);
        get_byte(0, "R9 refilled byte");
        bus_stop();

        // R11 repeated start mid-byte
        bus_start();
        put_byte({7'h3A, 1'b0}, 1, "R11 ack before restart");
        drive_bit(1'b1, 0); drive_bit(1'b0, 0); drive_bit(1'b1, 0);
        bus_start();
        put_byte({7'h3A, 1'b0}, 1, "R11 ack after restart");
        put_byte(8'h66, 0, "R11 ack data after restart");
        chk("R11 word address after restart", {7'b0, rx_is_waddr}, 8'h01);
        host_rd(8'h66, "R11 read data");
        bus_stop();

        wclk(10);
        report();
    end
endmodule